// File: doc/BRIEF.md
# ATA Automatic Status Sequencer

This block runs the device-side status handshakes of an ATA/ATAPI task file in hardware, so firmware does not have to step through them. Firmware sets a small group of enable bits and pulses trigger strobes. The sequencer then drives the BSY and DSC status bits and the host interrupt request, and it clears its own enables when a sequence finishes.

The status-complete action can start automatically when an Ultra DMA burst ends. A CRC-gating enable blocks that automatic start when the burst that just finished reported a CRC error. The seek-complete action is a fixed chain of one-cycle steps: raise BSY, set DSC, drop BSY, then retire the pending trigger. A host write of the packet opcode to the command register can also raise the interrupt when both packet enables are set.

Top module: `ata_auto_status_seq`

## Requirements
- R1: A synchronous active-high reset clears all enables, the pending seek trigger, BSY, DSC, the interrupt request and the status-complete pulse.
- R2: A write strobe `en_wr` loads `en_wdata` into `en_state` on the next cycle. The bit map is: bit 0 packet-interrupt enable, bit 1 auto-BSY enable, bit 2 CRC-gating enable, bit 3 automatic status-complete enable, bit 4 packet-feature enable.
- R3: When `burst_done` arrives with bit 3 set, and either bit 2 is clear or `burst_crc_err` is low, `status_done` pulses high the next cycle and `hirq` is set.
- R4: When `burst_done` arrives with bits 3 and 2 set and `burst_crc_err` high, no status-complete pulse follows and bit 2 stays set.
- R5: CRC gating is only a qualifier: `burst_done` with bit 3 clear never produces a status-complete pulse, whatever bit 2 holds.
- R6: A firmware `status_trig` pulse always runs the status-complete action. Bit 2 clears in the same cycle the action runs, whether the action was started by `status_trig` or by `burst_done`.
- R7: With bit 1 set, a `seek_trig` pulse in cycle c gives `seek_pend`=1 after edge c+1, `bsy`=1 after c+2, `dsc`=1 after c+3 and `bsy`=0 after c+4.
- R8: After edge c+5 the sequence has cleared `seek_pend` and bit 1, and it has returned to idle. DSC stays set until reset.
- R9: A `seek_trig` pulse while bit 1 is clear has no effect on `seek_pend`, `bsy` or `dsc`.
- R10: A `seek_trig` pulse while a seek sequence is running is ignored, and the running sequence keeps its timing.
- R11: A host command write of opcode A0h with bits 0 and 4 both set drives `hirq` high on the next cycle.
- R12: An A0h write with bit 0 or bit 4 clear, or a write of any other opcode, leaves `hirq` low.
- R13: `hirq` stays high until an `irq_clr` pulse. A set and a clear in the same cycle leave it high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_wr | input | 1 | Load strobe for the enable bits |
| en_wdata | input | 5 | Enable values (map in R2) |
| status_trig | input | 1 | Firmware status-complete trigger strobe |
| seek_trig | input | 1 | Firmware seek-complete trigger strobe |
| burst_done | input | 1 | End of an Ultra DMA burst |
| burst_crc_err | input | 1 | The burst ending now had a CRC error |
| host_cmd_wr | input | 1 | Host write to the command register |
| host_cmd | input | CMD_W | Opcode written by the host |
| irq_clr | input | 1 | Firmware clear of the interrupt request |
| en_state | output | 5 | Current enable bits |
| seek_pend | output | 1 | Seek-complete trigger still pending |
| bsy | output | 1 | BSY status bit |
| dsc | output | 1 | DSC status bit |
| hirq | output | 1 | Host interrupt request, active high |
| status_done | output | 1 | One-cycle pulse when status-complete runs |

## Verification
The CRC-blocking property assumes that `burst_crc_err` is valid in the same cycle as `burst_done`. It also assumes that no `status_trig` pulse arrives in that cycle, because a firmware trigger overrides the gate. The ordering properties on BSY, DSC and the pending flag assume that only the seek sequence drives them. The stimulus therefore pulses every strobe for exactly one cycle, always presents the CRC flag together with `burst_done`, and keeps firmware triggers apart from burst ends, except where a case is built on purpose to show that an overlapping trigger is ignored.

// File: rtl/ata_seq_pkg.sv
package ata_seq_pkg;

    // Enable bits; the packed order gives the bit map of en_wdata/en_state
    typedef struct packed {
        logic pkt_feat;   // bit 4
        logic auto_stat;  // bit 3
        logic crc_gate;   // bit 2
        logic auto_busy;  // bit 1
        logic pkt_irq;    // bit 0
    } en_t;

    localparam int EN_W = $bits(en_t);

    typedef enum logic [2:0] {
        SK_IDLE,
        SK_RAISE,
        SK_MARK,
        SK_DROP,
        SK_RETIRE
    } seek_st_t;

    // Automatic status-complete qualifier for a finished burst
    function automatic logic status_allowed(en_t e, logic crc_err);
        return e.auto_stat && !(e.crc_gate && crc_err);
    endfunction

endpackage

// File: rtl/ata_seq_enables.sv
module ata_seq_enables
    import ata_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  en_t  wdata,
    input  logic drop_crc_gate,
    input  logic drop_auto_busy,
    output en_t  en_q
);

    en_t en_d;

    always_comb begin
        en_d = wr ? wdata : en_q;
        // self-clearing has priority over a firmware write
        if (drop_crc_gate)  en_d.crc_gate  = 1'b0;
        if (drop_auto_busy) en_d.auto_busy = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) en_q <= '0;
        else     en_q <= en_d;
    end

endmodule

// File: rtl/ata_seq_seek.sv
module ata_seq_seek
    import ata_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic auto_busy_en,
    input  logic trig,
    output logic bsy,
    output logic dsc,
    output logic pend,
    output logic drop_auto_busy
);

    seek_st_t st_q, st_d;
    logic     bsy_d, dsc_d, pend_d;

    always_comb begin
        st_d   = st_q;
        bsy_d  = bsy;
        dsc_d  = dsc;
        pend_d = pend;
        unique case (st_q)
            SK_IDLE: begin
                if (trig && auto_busy_en) begin
                    pend_d = 1'b1;
                    st_d   = SK_RAISE;
                end
            end
            SK_RAISE: begin
                bsy_d = 1'b1;
                st_d  = SK_MARK;
            end
            SK_MARK: begin
                dsc_d = 1'b1;
                st_d  = SK_DROP;
            end
            SK_DROP: begin
                bsy_d = 1'b0;
                st_d  = SK_RETIRE;
            end
            SK_RETIRE: begin
                pend_d = 1'b0;
                st_d   = SK_IDLE;
            end
            default: st_d = SK_IDLE;
        endcase
    end

    assign drop_auto_busy = (st_q == SK_RETIRE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= SK_IDLE;
            bsy  <= 1'b0;
            dsc  <= 1'b0;
            pend <= 1'b0;
        end else begin
            st_q <= st_d;
            bsy  <= bsy_d;
            dsc  <= dsc_d;
            pend <= pend_d;
        end
    end

endmodule

// File: rtl/ata_seq_status.sv
module ata_seq_status
    import ata_seq_pkg::*;
#(
    parameter int              CMD_W      = 8,
    parameter logic [CMD_W-1:0] PKT_OPCODE = 8'hA0
) (
    input  logic             clk,
    input  logic             rst,
    input  en_t              en,
    input  logic             burst_done,
    input  logic             burst_crc_err,
    input  logic             status_trig,
    input  logic             host_cmd_wr,
    input  logic [CMD_W-1:0] host_cmd,
    input  logic             irq_clr,
    output logic             status_done,
    output logic             hirq,
    output logic             drop_crc_gate
);

    logic run, pkt_hit, hirq_d;

    assign run           = status_trig || (burst_done && status_allowed(en, burst_crc_err));
    assign drop_crc_gate = run;
    assign pkt_hit       = host_cmd_wr && (host_cmd == PKT_OPCODE) && en.pkt_irq && en.pkt_feat;

    always_comb begin
        if (run || pkt_hit) hirq_d = 1'b1;
        else if (irq_clr)   hirq_d = 1'b0;
        else                hirq_d = hirq;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_done <= 1'b0;
            hirq        <= 1'b0;
        end else begin
            status_done <= run;
            hirq        <= hirq_d;
        end
    end

endmodule

// File: rtl/ata_auto_status_seq.sv
module ata_auto_status_seq
    import ata_seq_pkg::*;
#(
    parameter int               CMD_W      = 8,
    parameter logic [CMD_W-1:0] PKT_OPCODE = 8'hA0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_wr,
    input  logic [4:0]       en_wdata,
    input  logic             status_trig,
    input  logic             seek_trig,
    input  logic             burst_done,
    input  logic             burst_crc_err,
    input  logic             host_cmd_wr,
    input  logic [CMD_W-1:0] host_cmd,
    input  logic             irq_clr,
    output logic [4:0]       en_state,
    output logic             seek_pend,
    output logic             bsy,
    output logic             dsc,
    output logic             hirq,
    output logic             status_done
);

    en_t  en_q;
    logic drop_crc_gate, drop_auto_busy;

    ata_seq_enables u_en (
        .clk            (clk),
        .rst            (rst),
        .wr             (en_wr),
        .wdata          (en_t'(en_wdata)),
        .drop_crc_gate  (drop_crc_gate),
        .drop_auto_busy (drop_auto_busy),
        .en_q           (en_q)
    );

    ata_seq_seek u_seek (
        .clk            (clk),
        .rst            (rst),
        .auto_busy_en   (en_q.auto_busy),
        .trig           (seek_trig),
        .bsy            (bsy),
        .dsc            (dsc),
        .pend           (seek_pend),
        .drop_auto_busy (drop_auto_busy)
    );

    ata_seq_status #(.CMD_W(CMD_W), .PKT_OPCODE(PKT_OPCODE)) u_stat (
        .clk           (clk),
        .rst           (rst),
        .en            (en_q),
        .burst_done    (burst_done),
        .burst_crc_err (burst_crc_err),
        .status_trig   (status_trig),
        .host_cmd_wr   (host_cmd_wr),
        .host_cmd      (host_cmd),
        .irq_clr       (irq_clr),
        .status_done   (status_done),
        .hirq          (hirq),
        .drop_crc_gate (drop_crc_gate)
    );

    assign en_state = en_q;

endmodule

// File: rtl/ata_seq_checker.sv
module ata_seq_checker #(
    parameter int               CMD_W      = 8,
    parameter logic [CMD_W-1:0] PKT_OPCODE = 8'hA0
) (
    input logic             clk,
    input logic             rst,
    input logic             status_trig,
    input logic             burst_done,
    input logic             burst_crc_err,
    input logic             host_cmd_wr,
    input logic [CMD_W-1:0] host_cmd,
    input logic             irq_clr,
    input logic [4:0]       en_state,
    input logic             seek_pend,
    input logic             bsy,
    input logic             dsc,
    input logic             hirq,
    input logic             status_done
);

    logic rst_seen;
    always_ff @(posedge clk) rst_seen <= rst;

    always @(negedge clk) begin
        if (rst_seen === 1'b1) begin
            assert_reset_clear_R1: assert (en_state == '0 && !seek_pend && !bsy && !dsc && !hirq && !status_done);
        end
    end

    assert_dsc_after_bsy_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(dsc) |-> (bsy && $past(bsy)));

    assert_bsy_drop_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(bsy) |-> dsc);

    assert_pend_retire_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(seek_pend) |-> (!bsy && !en_state[1]));

    assert_crc_block_R4: assert property (@(posedge clk) disable iff (rst)
        (burst_done && burst_crc_err && en_state[3] && en_state[2] && !status_trig) |=> !status_done);

    assert_gate_clear_R6: assert property (@(posedge clk) disable iff (rst)
        status_done |-> !en_state[2]);

    assert_pkt_irq_R11: assert property (@(posedge clk) disable iff (rst)
        (host_cmd_wr && host_cmd == PKT_OPCODE && en_state[0] && en_state[4]) |=> hirq);

    assert_irq_hold_R13: assert property (@(posedge clk) disable iff (rst)
        (hirq && !irq_clr) |=> hirq);

endmodule

bind ata_auto_status_seq ata_seq_checker #(.CMD_W(CMD_W), .PKT_OPCODE(PKT_OPCODE)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .status_trig   (status_trig),
    .burst_done    (burst_done),
    .burst_crc_err (burst_crc_err),
    .host_cmd_wr   (host_cmd_wr),
    .host_cmd      (host_cmd),
    .irq_clr       (irq_clr),
    .en_state      (en_state),
    .seek_pend     (seek_pend),
    .bsy           (bsy),
    .dsc           (dsc),
    .hirq          (hirq),
    .status_done   (status_done)
);

// File: tb/ata_auto_status_seq_tb.sv
module ata_auto_status_seq_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       en_wr, status_trig, seek_trig, burst_done, burst_crc_err;
    logic       host_cmd_wr, irq_clr;
    logic [4:0] en_wdata;
    logic [7:0] host_cmd;
    logic [4:0] en_state;
    logic       seek_pend, bsy, dsc, hirq, status_done;

    always #2.5 clk = ~clk;   // 200 MHz

    ata_auto_status_seq u_dut (
        .clk(clk), .rst(rst), .en_wr(en_wr), .en_wdata(en_wdata),
        .status_trig(status_trig), .seek_trig(seek_trig),
        .burst_done(burst_done), .burst_crc_err(burst_crc_err),
        .host_cmd_wr(host_cmd_wr), .host_cmd(host_cmd), .irq_clr(irq_clr),
        .en_state(en_state), .seek_pend(seek_pend), .bsy(bsy), .dsc(dsc),
        .hirq(hirq), .status_done(status_done)
    );

    // observation vector: [4:0] enables, 5 pend, 6 bsy, 7 dsc, 8 hirq, 9 done
    localparam logic [9:0] M_EN   = 10'h01F;
    localparam logic [9:0] M_PEND = 10'h020;
    localparam logic [9:0] M_BSY  = 10'h040;
    localparam logic [9:0] M_DSC  = 10'h080;
    localparam logic [9:0] M_IRQ  = 10'h100;
    localparam logic [9:0] M_DONE = 10'h200;

    typedef struct {
        int         at;
        logic [9:0] mask;
        logic [9:0] val;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    wire [9:0] obs = {status_done, hirq, dsc, bsy, seek_pend, en_state};

    // monitor: compares every expectation due in this cycle
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].at == cyc) begin
                n_chk++;
                if ((obs & q[i].mask) !== (q[i].val & q[i].mask)) begin
                    n_fail++;
                    $display("FAIL %s cycle %0d: actual %b expected %b (mask %b)",
                             q[i].tag, cyc, obs & q[i].mask, q[i].val & q[i].mask, q[i].mask);
                end
                q.delete(i);
            end
        end
    end

    task automatic expect_at(int dly, logic [9:0] mask, logic [9:0] val, string tag);
        exp_t e;
        e.at = cyc + dly; e.mask = mask; e.val = val; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic idle_inputs();
        en_wr = 0; status_trig = 0; seek_trig = 0; burst_done = 0;
        burst_crc_err = 0; host_cmd_wr = 0; irq_clr = 0;
    endtask

    task automatic do_reset();
        rst = 1; idle_inputs(); en_wdata = '0; host_cmd = '0;
        step(); step(); step();
        rst = 0;
    endtask

    task automatic write_en(logic [4:0] v);
        en_wr = 1; en_wdata = v;
        expect_at(1, M_EN, {5'b0, v}, "R2 enable load");
        step(); idle_inputs();
    endtask

    task automatic burst(logic err, logic runs, string tag);
        burst_done = 1; burst_crc_err = err;
        expect_at(1, M_DONE, runs ? M_DONE : 10'h0, tag);
        step(); idle_inputs();
    endtask

    task automatic host_write(logic [7:0] op, logic irq_exp, string tag);
        host_cmd_wr = 1; host_cmd = op;
        expect_at(1, M_IRQ, irq_exp ? M_IRQ : 10'h0, tag);
        step(); idle_inputs();
    endtask

    task automatic clear_irq();
        irq_clr = 1;
        expect_at(1, M_IRQ, 10'h0, "R13 clear strobe");
        step(); idle_inputs();
    endtask

    task automatic drain();
        repeat (8) step();
    endtask

    initial begin
        do_reset();
        // R1: reset state
        expect_at(0, 10'h3FF, 10'h0, "R1 reset state");
        step();

        // R2: enable load
        write_en(5'b01010);
        drain();

        // R4: gate with error blocks, gate kept
        write_en(5'b01100);
        burst(1'b1, 1'b0, "R4 crc error blocks");
        expect_at(0, 10'h004, 10'h004, "R4 gate kept");
        step();
        // R3 / R6: clean burst runs and clears gate
        burst(1'b0, 1'b1, "R3 clean burst runs");
        expect_at(0, M_IRQ | 10'h004, M_IRQ, "R3 irq set, R6 gate cleared");
        step();
        clear_irq();
        drain();

        // R3: gate clear, error burst still runs
        write_en(5'b01000);
        burst(1'b1, 1'b1, "R3 ungated error burst runs");
        clear_irq();

        // R5: gate alone without automatic enable
        write_en(5'b00100);
        burst(1'b0, 1'b0, "R5 no auto enable");
        expect_at(0, M_IRQ, 10'h0, "R5 no irq");
        step();

        // R6: firmware trigger runs and clears gate
        write_en(5'b01100);
        status_trig = 1;
        expect_at(1, M_DONE | 10'h004, M_DONE, "R6 firmware trigger");
        step(); idle_inputs();
        clear_irq();
        drain();

        // R7 / R8 / R10: seek sequence with an overlapping trigger
        write_en(5'b00010);
        seek_trig = 1;
        expect_at(1, M_PEND | M_BSY | M_DSC, M_PEND,                 "R7 step pend");
        expect_at(2, M_PEND | M_BSY | M_DSC, M_PEND | M_BSY,         "R7 step bsy");
        expect_at(3, M_PEND | M_BSY | M_DSC, M_PEND | M_BSY | M_DSC, "R7 step dsc");
        expect_at(4, M_PEND | M_BSY | M_DSC, M_PEND | M_DSC,         "R7 step unbsy");
        expect_at(5, M_PEND | M_BSY | M_DSC | 10'h002, M_DSC,        "R8 retire");
        expect_at(6, M_PEND | M_BSY | M_DSC, M_DSC,                  "R10 no restart");
        expect_at(7, M_PEND | M_BSY, 10'h0,                          "R10 still idle");
        step(); idle_inputs();
        step();
        seek_trig = 1;   // arrives while the sequence runs
        step(); idle_inputs();
        drain();

        // R9: no auto-BSY enable
        do_reset();
        write_en(5'b00000);
        seek_trig = 1;
        expect_at(1, M_PEND | M_BSY | M_DSC, 10'h0, "R9 ignored a");
        expect_at(3, M_PEND | M_BSY | M_DSC, 10'h0, "R9 ignored b");
        step(); idle_inputs();
        drain();

        // R11 / R13: packet interrupt and hold
        write_en(5'b10001);
        host_write(8'hA0, 1'b1, "R11 packet irq");
        step(); step();
        expect_at(0, M_IRQ, M_IRQ, "R13 held");
        step();
        irq_clr = 1; host_cmd_wr = 1; host_cmd = 8'hA0;
        expect_at(1, M_IRQ, M_IRQ, "R13 set wins");
        step(); idle_inputs();
        clear_irq();

        // R12: missing enables or other opcode
        host_write(8'hEC, 1'b0, "R12 other opcode");
        write_en(5'b00001);
        host_write(8'hA0, 1'b0, "R12 no feature enable");
        write_en(5'b10000);
        host_write(8'hA0, 1'b0, "R12 no irq enable");
        drain();

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule